// File: doc/BRIEF.md
# Daisy-Chained Segment FIFO

This block builds one deep first-in/first-out queue from a ring of small, independent storage segments. Each segment keeps its own write and read pointers, its own word count and its own active-low empty and full indications. There is no global pointer. Instead, two ownership tokens travel around the ring: one for writing and one for reading. The segment that holds the write token takes the next incoming word, and the segment that holds the read token supplies the next outgoing word.

When a segment stores into its last physical location, it pulses its expansion output tagged as write-side. The next segment in the ring takes that pulse on its expansion input and owns the write token from the following cycle. The read side hands over the same way when the read pointer leaves the last location. The last segment's expansion output feeds the first segment's expansion input, which closes the ring. A compile-time first-load selection decides which segment owns both tokens after reset.

The whole chain behaves as a show-ahead queue of SEGS×SEG_DEPTH words. The composite empty and full outputs are formed by combining the per-segment active-low flags, so that any one segment's assertion asserts the composite flag.

Top module: `cascade_fifo`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, empty_n is 0 and full_n is 1. Every segment's pointers and count are cleared, and the segment named by FIRST_SEG owns both the write token and the read token.
- R2: Words leave in the order they were accepted, across any number of token handoffs. The total capacity is SEGS×SEG_DEPTH words.
- R3: A write into a segment's last location moves the write token to the next segment for the following cycle. From the last segment, the token wraps to segment 0. Exactly one segment holds the write token at all times.
- R4: A read from a segment's last location moves the read token under the same rule as R3. Exactly one segment holds the read token at all times.
- R5: full_n is 0 exactly when SEGS×SEG_DEPTH words are held. While full_n is 0, a write is ignored, and the contents read out afterwards show no trace of it.
- R6: empty_n is 0 exactly when no word is held. While empty_n is 0, a read is ignored and rd_data is all zeros.
- R7: Changing FIRST_SEG moves the starting segment but leaves the port behaviour of R1 to R6 unchanged.
- R8: Acceptance of a write and of a read in the same cycle is decided on the state before the clock edge. If the queue is full, the read is accepted and the write is dropped. If the queue is empty, the write is accepted and the read is dropped. Otherwise both are accepted.
- R9: While empty_n is 1, rd_data shows the oldest held word, driven only by the segment holding the read token. An accepted read (rd_en high at a rising clk edge) advances rd_data to the next word after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, sampled at the rising edge |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request, sampled at the rising edge |
| rd_data | output | WIDTH | Oldest held word; zero when empty |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a write and a read arriving together at the empty or the full boundary. The second pair is a write-token handoff in one segment and a read-token handoff in another segment. The bench provokes the boundary pair on purpose: it issues combined requests right after reset and again once the queue is full. It then runs a long stretch of mixed traffic, biased toward writing for a while and toward reading for a while, which makes the two handoffs coincide many times, including wraps from the last segment back to the first. Every cycle is judged against a behavioural queue that decides acceptance from its own occupancy before the edge. A second instance with a different first segment receives the same stimulus and must match the same queue.

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int SEGS      = 3,
  parameter int SEG_DEPTH = 4,
  parameter int WIDTH     = 9,
  parameter int FIRST_SEG = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             full_n
);
  localparam int AW = (SEG_DEPTH > 1) ? $clog2(SEG_DEPTH) : 1;
  localparam logic [AW-1:0]   LAST_LOC     = AW'(SEG_DEPTH - 1);
  localparam logic [AW:0]     SEG_WORDS    = (AW+1)'(SEG_DEPTH);
  localparam logic [SEGS-1:0] FIRST_LOAD_N = ~(SEGS'(1) << FIRST_SEG);

  logic [SEGS-1:0] wtok, rtok, seg_empty_n, seg_full_n;
  logic [SEGS-1:0] xo_w, xo_r, xi_w, xi_r;
  logic [WIDTH-1:0] head [SEGS];
  logic wr_go, rd_go;

  assign empty_n = &seg_empty_n;
  assign full_n  = &seg_full_n;
  assign wr_go   = wr_en & full_n;
  assign rd_go   = rd_en & empty_n;

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    localparam int PREV = (i == 0) ? SEGS - 1 : i - 1;
    logic [WIDTH-1:0] mem [SEG_DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wt_q, rt_q, we, re;

    assign xi_w[i] = xo_w[PREV];
    assign xi_r[i] = xo_r[PREV];
    assign wtok[i] = wt_q;
    assign rtok[i] = rt_q;

    assign we      = wr_go & wt_q;
    assign re      = rd_go & rt_q;
    assign xo_w[i] = we & (wp == LAST_LOC);
    assign xo_r[i] = re & (rp == LAST_LOC);

    assign seg_empty_n[i] = !(rt_q && cnt == '0);
    assign seg_full_n[i]  = !(wt_q && cnt == SEG_WORDS);
    assign head[i]        = (rt_q && cnt != '0) ? mem[rp] : '0;

    always_ff @(posedge clk) begin
      if (we) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp   <= '0;
        rp   <= '0;
        cnt  <= '0;
        wt_q <= !FIRST_LOAD_N[i];
        rt_q <= !FIRST_LOAD_N[i];
      end else begin
        if (we) wp <= (wp == LAST_LOC) ? '0 : wp + 1'b1;
        if (re) rp <= (rp == LAST_LOC) ? '0 : rp + 1'b1;
        cnt  <= cnt + (AW+1)'(we) - (AW+1)'(re);
        wt_q <= (wt_q & ~xo_w[i]) | xi_w[i];
        rt_q <= (rt_q & ~xo_r[i]) | xi_r[i];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SEGS; i++) rd_data = rd_data | head[i];
  end
endmodule

// File: rtl/cascade_fifo_chk.sv
module cascade_fifo_chk #(
  parameter int SEGS      = 3,
  parameter int WIDTH     = 9,
  parameter int FIRST_SEG = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             empty_n,
  input logic             full_n,
  input logic [SEGS-1:0]  wtok,
  input logic [SEGS-1:0]  rtok
);
  localparam logic [SEGS-1:0] START = SEGS'(1) << FIRST_SEG;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!empty_n && full_n && wtok == START && rtok == START));

  // R3
  wtok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok) == 1);

  // R4
  rtok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok) == 1);

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en && !rd_en) |=> !full_n);

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en && !wr_en) |=> !empty_n);

  // R6
  empty_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> rd_data == '0);

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));
endmodule

bind cascade_fifo cascade_fifo_chk #(
  .SEGS(SEGS), .WIDTH(WIDTH), .FIRST_SEG(FIRST_SEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
  .wtok(wtok), .rtok(rtok)
);

// File: tb/cascade_fifo_bench.sv
module cascade_fifo_bench;
  localparam int SEGS = 3, DEPTH = 4, W = 9, CAP = SEGS * DEPTH;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wr_en, rd_en;
  logic [W-1:0] wr_data, rd_a, rd_b;
  logic emp_a, full_a, emp_b, full_b;

  cascade_fifo #(.SEGS(SEGS), .SEG_DEPTH(DEPTH), .WIDTH(W), .FIRST_SEG(0)) u_cascade_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_a), .empty_n(emp_a), .full_n(full_a));

  cascade_fifo #(.SEGS(SEGS), .SEG_DEPTH(DEPTH), .WIDTH(W), .FIRST_SEG(2)) u_cascade_fifo_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_b), .empty_n(emp_b), .full_n(full_b));

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int q[$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int e_emp, e_full, e_dat;
    e_emp  = (q.size() != 0);
    e_full = (q.size() != CAP);
    e_dat  = (q.size() != 0) ? q[0] : 0;
    chk(tag, "empty_n", int'(emp_a), e_emp);
    chk(tag, "full_n", int'(full_a), e_full);
    chk(tag, "rd_data", int'(rd_a), e_dat);
    chk({"R7 ", tag}, "alt empty_n", int'(emp_b), e_emp);
    chk({"R7 ", tag}, "alt full_n", int'(full_b), e_full);
    chk({"R7 ", tag}, "alt rd_data", int'(rd_b), e_dat);
  endtask

  task automatic step(bit w, int d, bit r, string tag);
    bit push, pop;
    wr_en = w; wr_data = W'(d); rd_en = r;
    @(posedge clk);
    pop  = r && q.size() > 0;
    push = w && q.size() < CAP;
    if (pop)  void'(q.pop_front());
    if (push) q.push_back(d & ((1 << W) - 1));
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1 compare("R1");
    @(negedge clk);
    step(0, 0, 1, "R6");
    step(0, 0, 1, "R6");
    step(1, 5, 1, "R8");
    step(0, 0, 1, "R9");
    for (int k = 0; k < CAP; k++) step(1, k + 16, 0, "R3");
    step(1, 99, 0, "R5");
    step(1, 98, 0, "R5");
    step(1, 77, 1, "R8");
    step(1, 55, 0, "R5");
    for (int k = 0; k < CAP + 2; k++) step(0, 0, 1, "R4");
    void'($urandom(7));
    for (int n = 0; n < 4000; n++) begin
      bit fillph;
      fillph = (n % 300) < 150;
      step(($urandom_range(0, 3) != 0) == fillph,
           int'($urandom_range(0, 511)),
           ($urandom_range(0, 3) != 0) != fillph, "R2");
    end
    for (int k = 0; k < CAP + 1; k++) step(0, 0, 1, "R2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule